// File: doc/BRIEF.md
# Paged Stack RAM-Disk Mapper

This block is the address-mapping logic for a banked RAM-disk expansion attached to an 8-bit computer. Each expansion unit holds 256K arranged as four 64K pages, and up to eight units sit on the same CPU address space, giving 2MB in total. Software configures every unit by writing one byte to that unit's own I/O port. The byte decides which CPU memory cycles leave base RAM and go to the expansion, and which page they land on.

A unit can claim a cycle in three ways. Stack-type cycles (pushes, pops, calls and returns, flagged by the CPU side) can be sent to a chosen stack page. A 16K window over the screen region can show part of a chosen window page. Two further 8K windows, one just below and one just above the screen window, can be opened onto the same window page. Together with the screen window they make a 32K region of the page directly addressable. When several units claim the same cycle, the lowest-numbered one wins. A cycle that no unit claims goes to base RAM.

The mapper takes one access per clock and returns the translated 21-bit physical address one cycle later: the unit number, the page number and the untouched 16-bit CPU address, concatenated in that order. A flag says whether the address is in the expansion or in base RAM. The memory controller and the CPU core are outside this block.

Top module: `rdm_mapper`

## Requirements
- R1: After a synchronous reset every unit's configuration byte is zero and the outputs are zero. Until a port is written, every access maps to base RAM.
- R2: A write with `io_wr` high to port `PORT_BASE + u`, for u from 0 to 7, loads `io_data` into unit u only. Writes to any other port change no unit.
- R3: Configuration bit 0 enables stack mapping and bits 2:1 give the stack page. A stack cycle on a unit with bit 0 set maps to that unit's stack page.
- R4: Configuration bit 3 enables the screen window and bits 5:4 give the window page. A cycle at addresses 0xA000 to 0xDFFF maps to the window page when bit 3 is set. The bounds are inclusive.
- R5: Bit 6 opens a low 8K window at 0x8000 to 0x9FFF and bit 7 opens a high 8K window at 0xE000 to 0xFFFF. Both map to the window page, and neither depends on bit 3.
- R6: When more than one unit claims a cycle, the unit with the lowest number is used.
- R7: A cycle claimed by no unit gives `map_ext` = 0 and `map_addr` = {5'b0, cpu address}.
- R8: `map_valid` follows `acc_valid` by exactly one clock. When no access is presented, the next cycle shows `map_ext` = 0 and `map_addr` = 0. A configuration write takes effect on accesses presented in the cycle after the write, not on an access presented in the same cycle.
- R9: On a claimed cycle `map_addr` = {unit[2:0], page[1:0], cpu address[15:0]}. Within a unit, a stack cycle with stack mapping enabled uses the stack page even when its address also falls inside an open window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_wr | input | 1 | I/O write strobe |
| io_port | input | 8 | I/O port number |
| io_data | input | 8 | I/O write data (configuration byte) |
| acc_valid | input | 1 | A CPU memory access is presented this cycle |
| acc_stack | input | 1 | The access is a stack-type cycle |
| acc_addr | input | 16 | CPU address of the access |
| map_valid | output | 1 | Registered: a translated access is available |
| map_ext | output | 1 | Registered: the access goes to the expansion |
| map_addr | output | 21 | Registered physical address |

## Verification
Directed patterns come first. Every port is written with a stack-enable configuration, and then units are disabled one at a time, so each step shows which unit wins priority. Accesses just inside and just outside each window bound separate the screen window from the two 8K windows and from base RAM. Stack and ordinary cycles at the same address show that stack mapping takes precedence over a window. An access presented in the same cycle as a configuration write shows that the old configuration is still in use. A seeded random phase then mixes port writes, including writes to unused ports, with accesses biased toward the window edges, and checks each result against a bench model of all eight configuration bytes.

// File: rtl/rdm_pkg.sv
package rdm_pkg;
  localparam int PAGE_W = 2;

  // configuration byte, MSB first
  typedef struct packed {
    logic              ext_hi;    // bit 7: high 8K window
    logic              ext_lo;    // bit 6: low 8K window
    logic [PAGE_W-1:0] win_page;  // bits 5:4
    logic              win_en;    // bit 3: screen window
    logic [PAGE_W-1:0] stk_page;  // bits 2:1
    logic              stk_en;    // bit 0: stack mapping
  } rdm_cfg_t;

  localparam int CFG_W = $bits(rdm_cfg_t);
endpackage

// File: rtl/rdm_cfg_bank.sv
module rdm_cfg_bank
  import rdm_pkg::*;
#(
  parameter int NUM_UNITS = 8,
  parameter int PORT_W    = 8,
  parameter int PORT_BASE = 16
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        io_wr,
  input  logic [PORT_W-1:0]           io_port,
  input  logic [CFG_W-1:0]            io_data,
  output rdm_cfg_t [NUM_UNITS-1:0]    cfg_q
);
  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
    logic hit;
    assign hit = io_wr && (io_port == PORT_W'(PORT_BASE + u));
    always_ff @(posedge clk) begin
      if (rst)      cfg_q[u] <= '0;
      else if (hit) cfg_q[u] <= rdm_cfg_t'(io_data);
    end
  end
endmodule

// File: rtl/rdm_unit_claim.sv
module rdm_unit_claim
  import rdm_pkg::*;
#(
  parameter int CPU_AW   = 16,
  parameter int WIN_BASE = 'hA000,
  parameter int WIN_SIZE = 'h4000,
  parameter int LO_BASE  = 'h8000,
  parameter int HI_BASE  = 'hE000,
  parameter int EXT_SIZE = 'h2000
) (
  input  rdm_cfg_t          cfg,
  input  logic              acc_stack,
  input  logic [CPU_AW-1:0] acc_addr,
  output logic              claim,
  output logic [PAGE_W-1:0] page
);
  localparam int CMP_W = CPU_AW + 1;
  logic [CMP_W-1:0] a_ext;
  logic in_win, in_lo, in_hi, stk_hit, win_hit;

  assign a_ext  = {1'b0, acc_addr};
  assign in_win = (a_ext >= CMP_W'(WIN_BASE)) && (a_ext < CMP_W'(WIN_BASE + WIN_SIZE));
  assign in_lo  = (a_ext >= CMP_W'(LO_BASE))  && (a_ext < CMP_W'(LO_BASE + EXT_SIZE));
  assign in_hi  = (a_ext >= CMP_W'(HI_BASE))  && (a_ext < CMP_W'(HI_BASE + EXT_SIZE));

  assign stk_hit = acc_stack && cfg.stk_en;
  assign win_hit = (cfg.win_en && in_win) || (cfg.ext_lo && in_lo) || (cfg.ext_hi && in_hi);

  always_comb begin
    claim = stk_hit || win_hit;
    page  = stk_hit ? cfg.stk_page : cfg.win_page;
  end
endmodule

// File: rtl/rdm_select.sv
module rdm_select
  import rdm_pkg::*;
#(
  parameter int NUM_UNITS = 8,
  parameter int CPU_AW    = 16,
  localparam int UNIT_W   = (NUM_UNITS > 1) ? $clog2(NUM_UNITS) : 1,
  localparam int PHYS_AW  = UNIT_W + PAGE_W + CPU_AW
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            acc_valid,
  input  logic [CPU_AW-1:0]               acc_addr,
  input  logic [NUM_UNITS-1:0]            claim,
  input  logic [NUM_UNITS-1:0][PAGE_W-1:0] page,
  output logic                            map_valid,
  output logic                            map_ext,
  output logic [PHYS_AW-1:0]              map_addr
);
  logic              any;
  logic [UNIT_W-1:0] win_u;
  logic [PAGE_W-1:0] win_p;

  // scan from the top down so the lowest claiming unit is left standing
  always_comb begin
    any   = 1'b0;
    win_u = '0;
    win_p = '0;
    for (int u = NUM_UNITS - 1; u >= 0; u--) begin
      if (claim[u]) begin
        any   = 1'b1;
        win_u = UNIT_W'(u);
        win_p = page[u];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      map_valid <= 1'b0;
      map_ext   <= 1'b0;
      map_addr  <= '0;
    end else begin
      map_valid <= acc_valid;
      map_ext   <= acc_valid && any;
      if (!acc_valid)  map_addr <= '0;
      else if (any)    map_addr <= {win_u, win_p, acc_addr};
      else             map_addr <= {{(UNIT_W + PAGE_W){1'b0}}, acc_addr};
    end
  end
endmodule

// File: rtl/rdm_mapper.sv
module rdm_mapper
  import rdm_pkg::*;
#(
  parameter int NUM_UNITS = 8,
  parameter int PORT_W    = 8,
  parameter int PORT_BASE = 16,
  parameter int CPU_AW    = 16,
  localparam int UNIT_W   = (NUM_UNITS > 1) ? $clog2(NUM_UNITS) : 1,
  localparam int PHYS_AW  = UNIT_W + PAGE_W + CPU_AW
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               io_wr,
  input  logic [PORT_W-1:0]  io_port,
  input  logic [7:0]         io_data,
  input  logic               acc_valid,
  input  logic               acc_stack,
  input  logic [CPU_AW-1:0]  acc_addr,
  output logic               map_valid,
  output logic               map_ext,
  output logic [PHYS_AW-1:0] map_addr
);
  rdm_cfg_t [NUM_UNITS-1:0]             cfg_q;
  logic     [NUM_UNITS-1:0]             claim;
  logic     [NUM_UNITS-1:0][PAGE_W-1:0] page;

  rdm_cfg_bank #(
    .NUM_UNITS(NUM_UNITS), .PORT_W(PORT_W), .PORT_BASE(PORT_BASE)
  ) i_bank (
    .clk(clk), .rst(rst), .io_wr(io_wr), .io_port(io_port),
    .io_data(io_data), .cfg_q(cfg_q)
  );

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_claim
    rdm_unit_claim #(.CPU_AW(CPU_AW)) i_claim (
      .cfg(cfg_q[u]), .acc_stack(acc_stack), .acc_addr(acc_addr),
      .claim(claim[u]), .page(page[u])
    );
  end

  rdm_select #(.NUM_UNITS(NUM_UNITS), .CPU_AW(CPU_AW)) i_sel (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_addr(acc_addr),
    .claim(claim), .page(page),
    .map_valid(map_valid), .map_ext(map_ext), .map_addr(map_addr)
  );
endmodule

// File: rtl/rdm_mapper_chk.sv
module rdm_mapper_chk
  import rdm_pkg::*;
(
  input logic        clk,
  input logic        rst,
  input logic        acc_valid,
  input logic        acc_stack,
  input logic [15:0] acc_addr,
  input rdm_cfg_t    cfg0,
  input logic        map_valid,
  input logic        map_ext,
  input logic [20:0] map_addr
);
  a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!map_valid && !map_ext && map_addr == '0));

  a_r8_valid_follows: assert property (@(posedge clk) disable iff (rst)
    acc_valid |=> map_valid);

  a_r8_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !acc_valid |=> (!map_valid && !map_ext && map_addr == '0));

  a_r7_base_upper_zero: assert property (@(posedge clk) disable iff (rst)
    (map_valid && !map_ext) |-> (map_addr[20:16] == 5'd0));

  a_r9_addr_passthrough: assert property (@(posedge clk) disable iff (rst)
    acc_valid |=> (map_addr[15:0] == $past(acc_addr)));

  // unit 0 owns every stack cycle once its stack bit is set (R3, R6)
  a_r3_unit0_stack: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && acc_stack && cfg0.stk_en) |=>
      (map_ext && map_addr[20:18] == 3'd0 && map_addr[17:16] == $past(cfg0.stk_page)));
endmodule

bind rdm_mapper rdm_mapper_chk i_chk (
  .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_stack(acc_stack),
  .acc_addr(acc_addr), .cfg0(cfg_q[0]), .map_valid(map_valid),
  .map_ext(map_ext), .map_addr(map_addr)
);

// File: tb/test_rdm_mapper.sv
`timescale 1ns/1ps
module test_rdm_mapper;
  localparam int PB = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        io_wr = 1'b0;
  logic [7:0]  io_port = '0;
  logic [7:0]  io_data = '0;
  logic        acc_valid = 1'b0;
  logic        acc_stack = 1'b0;
  logic [15:0] acc_addr = '0;
  logic        map_valid, map_ext;
  logic [20:0] map_addr;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;
  logic [7:0] mdl [8];

  always #5 clk = ~clk;

  rdm_mapper i_rdm_mapper (
    .clk(clk), .rst(rst), .io_wr(io_wr), .io_port(io_port), .io_data(io_data),
    .acc_valid(acc_valid), .acc_stack(acc_stack), .acc_addr(acc_addr),
    .map_valid(map_valid), .map_ext(map_ext), .map_addr(map_addr)
  );

  // expected {ext, addr} from the requirement text
  function automatic logic [21:0] expect_map(logic [15:0] a, logic s);
    for (int u = 0; u < 8; u++) begin
      logic [7:0] c;
      logic       win;
      c   = mdl[u];
      win = (c[3] && a >= 16'hA000 && a <= 16'hDFFF) ||
            (c[6] && a >= 16'h8000 && a <= 16'h9FFF) ||
            (c[7] && a >= 16'hE000);
      if (s && c[0]) return {1'b1, 3'(u), c[2:1], a};
      if (win)       return {1'b1, 3'(u), c[5:4], a};
    end
    return {1'b0, 5'd0, a};
  endfunction

  task automatic check(string req, logic [21:0] got, logic [21:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got ext=%0b addr=%06h, expected ext=%0b addr=%06h",
               req, got[21], got[20:0], exp[21], exp[20:0]);
    end
  endtask

  task automatic wr(logic [7:0] port, logic [7:0] data);
    @(negedge clk);
    acc_valid = 1'b0;
    io_wr = 1'b1; io_port = port; io_data = data;
    @(posedge clk);
    #1;
    io_wr = 1'b0;
    if (port >= PB && port < PB + 8) mdl[port - PB] = data;
  endtask

  task automatic acc(string req, logic [15:0] a, logic s);
    logic [21:0] e;
    @(negedge clk);
    acc_valid = 1'b1; acc_stack = s; acc_addr = a;
    e = expect_map(a, s);
    @(posedge clk);
    #1;
    check(req, {map_ext, map_addr}, e);
    n_chk++;
    if (map_valid !== 1'b1) begin
      n_fail++;
      $display("FAIL R8: map_valid got %0b expected 1", map_valid);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not complete, got timeout expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [21:0] e;
    for (int u = 0; u < 8; u++) mdl[u] = '0;
    void'($urandom(32'd20240419));
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    #1;
    // R1 reset state
    check("R1 reset outputs", {map_ext, map_addr}, 22'd0);
    acc("R1 base after reset stack", 16'h1234, 1'b1);
    acc("R1 base after reset window", 16'hB000, 1'b0);

    // R2 unused ports ignored
    wr(PB + 8, 8'hFF);
    wr(PB - 1, 8'hFF);
    acc("R2 ignored port stack", 16'hF000, 1'b1);
    acc("R2 ignored port window", 16'hA000, 1'b0);

    // R2/R3/R6 every port written, then peel units off one at a time
    for (int u = 0; u < 8; u++) wr(8'(PB + u), {5'd0, 2'(u), 1'b1});
    for (int u = 0; u < 8; u++) begin
      acc("R6 lowest unit wins (R3 stack page)", 16'h7FFE, 1'b1);
      wr(8'(PB + u), 8'h00);
    end
    acc("R7 all disabled base", 16'h7FFE, 1'b1);

    // R4 screen window bounds
    wr(PB + 3, 8'h28);
    acc("R4 window low edge", 16'hA000, 1'b0);
    acc("R4 window high edge", 16'hDFFF, 1'b0);
    acc("R4 below window", 16'h9FFF, 1'b0);
    acc("R4 above window", 16'hE000, 1'b0);
    // R5 extended windows
    wr(PB + 3, 8'h60);
    acc("R5 low ext start", 16'h8000, 1'b0);
    acc("R5 low ext end", 16'h9FFF, 1'b0);
    acc("R5 screen closed", 16'hA000, 1'b0);
    acc("R5 high closed", 16'hE000, 1'b0);
    wr(PB + 3, 8'hA0);
    acc("R5 high ext start", 16'hE000, 1'b0);
    acc("R5 high ext end", 16'hFFFF, 1'b0);
    acc("R5 below low ext", 16'h7FFF, 1'b0);
    // R9 stack precedence inside one unit
    wr(PB + 3, 8'h2B);
    acc("R9 stack in window uses stack page", 16'hA000, 1'b1);
    acc("R9 plain in window uses window page", 16'hA000, 1'b0);
    acc("R9 stack outside window", 16'h1000, 1'b1);
    wr(PB + 3, 8'h00);

    // R8 write and access in the same cycle: old config applies
    @(negedge clk);
    io_wr = 1'b1; io_port = 8'(PB + 2); io_data = 8'h07;
    acc_valid = 1'b1; acc_stack = 1'b1; acc_addr = 16'h4000;
    e = expect_map(16'h4000, 1'b1);
    @(posedge clk);
    #1;
    io_wr = 1'b0;
    mdl[2] = 8'h07;
    check("R8 same-cycle write uses old config", {map_ext, map_addr}, e);
    acc("R8 write visible next access", 16'h4000, 1'b1);
    // R8 idle cycle
    @(negedge clk) acc_valid = 1'b0;
    @(posedge clk);
    #1;
    check("R8 idle outputs", {map_ext ^ map_valid, map_addr}, 22'd0);
    n_chk++;
    if (map_valid !== 1'b0) begin
      n_fail++;
      $display("FAIL R8: idle map_valid got %0b expected 0", map_valid);
    end

    // random mix
    for (int i = 0; i < 600; i++) begin
      int r;
      r = int'($urandom_range(0, 9));
      if (r < 3) begin
        wr(8'(PB - 1 + int'($urandom_range(0, 9))), 8'($urandom));
      end else begin
        logic [15:0] a;
        case ($urandom_range(0, 3))
          0: a = 16'($urandom);
          1: a = 16'hA000 + 16'($urandom_range(0, 3)) - 16'd2;
          2: a = 16'hE000 + 16'($urandom_range(0, 3)) - 16'd2;
          default: a = 16'h8000 + 16'($urandom_range(0, 3)) - 16'd2;
        endcase
        acc("R9 random mapping", a, 1'($urandom));
      end
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule